// File: doc/BRIEF.md
# Retriggerable Edge-Triggered One-Shot

This block produces a single timed pulse on a clock-synchronous output each time it sees a qualified trigger edge. It has two trigger inputs of opposite sense, and each input gates the other. A rising edge on the positive trigger counts only while the negative trigger is LOW. A falling edge on the negative trigger counts only while the positive trigger is HIGH. The pulse length comes from a built-in time base, not from the trigger, so a trigger may be held for one cycle or for far longer than the pulse.

The time base is a digital oscillator that runs only while a pulse is active. It starts HIGH when a pulse begins and toggles every `HALF_CYC` clocks. A single shot ends on the oscillator's next rising edge, which gives exactly two half-periods. When the retrigger enable is HIGH together with a leading edge on the positive trigger, the rising-edge count is cleared without moving the oscillator phase. The pulse then ends on the second oscillator rising edge after the last retrigger, so the tail after the last retrigger varies with the phase at which it arrived. A master reset ends any pulse and blocks new ones while it is HIGH.

Top module: `oneshot_retrig`

## Requirements
- R1: While `rst` is HIGH, and after it, `pulse_o` is 0, `pulse_n` is 1 and `osc_o` is 0 until a trigger is taken.
- R2: From idle, a 0-to-1 change on `trig_pos` while `trig_neg` is 0 starts a pulse. `pulse_o` is first seen HIGH after the third rising clock edge following the input change.
- R3: From idle, a 1-to-0 change on `trig_neg` while `trig_pos` is 1 starts a pulse, with the same three-edge latency as R2.
- R4: A rise on `trig_pos` while `trig_neg` is 1, a fall on `trig_neg` while `trig_pos` is 0, a fall on `trig_pos` and a rise on `trig_neg` start no pulse.
- R5: Without retriggering, a pulse lasts exactly 2*`HALF_CYC` clock cycles, whether the trigger is held for one cycle or longer than the pulse.
- R6: While a pulse is active and `retrig_en` is 0, further trigger edges have no effect on its end time.
- R7: While a pulse is active, a rise on `trig_pos` with `trig_neg` 0 and `retrig_en` 1 clears the rising-edge count. The pulse then ends on the second rising edge of `osc_o` that follows, including the case where the retrigger lands exactly on a rising edge. Retriggers spaced 2*`HALF_CYC` cycles or closer keep the pulse HIGH without a gap.
- R8: `osc_o` is 1 in the first cycle of a pulse, toggles every `HALF_CYC` cycles while the pulse lasts, and is 0 whenever no pulse is active.
- R9: `mr` HIGH at a clock edge ends any pulse at that edge and clears `osc_o`. A trigger whose edge is decided while `mr` is HIGH is ignored.
- R10: `pulse_n` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr | input | 1 | Master reset: ends a pulse and blocks triggers (synchronous) |
| trig_pos | input | 1 | Positive-edge trigger, asynchronous |
| trig_neg | input | 1 | Negative-edge trigger, asynchronous |
| retrig_en | input | 1 | Retrigger enable, asynchronous |
| pulse_o | output | 1 | Pulse output, registered |
| pulse_n | output | 1 | Complement of the pulse output, registered |
| osc_o | output | 1 | Time-base oscillator tap, registered |

## Verification
The assertions assume that `mr` and `rst` are synchronous to `clk`, and that only the three trigger inputs are asynchronous. They also assume a minimum-width claim makes sense only for pulses that end on their own, not through `mr` or `rst`. The stimulus changes every input on the falling clock edge. Trigger inputs are held LOW through reset, so the synchronisers start from a known level. In the random phase, inputs toggle rarely and `mr` pulses are sparse, so most pulses run to their natural or retriggered end. A cycle model in the bench, built from the requirements, predicts all three outputs.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam int unsigned IN_BITS   = 3;
  localparam int unsigned IX_POS    = 0;
  localparam int unsigned IX_NEG    = 1;
  localparam int unsigned IX_RTG    = 2;
  localparam int unsigned END_RISES = 2;

  typedef struct packed {
    logic fire;
    logic extend;
  } trig_evt_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [2:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[1:0], din[i]};
    end
    assign cur[i]  = sh[1];
    assign prev[i] = sh[2];
  end
endmodule

// File: rtl/oneshot_edge_qual.sv
module oneshot_edge_qual
  import oneshot_pkg::*;
(
  input  logic [IN_BITS-1:0] cur,
  input  logic [IN_BITS-1:0] prev,
  output trig_evt_t          evt
);
  logic p_rise, n_fall, unused_prev;

  assign p_rise      = cur[IX_POS] & ~prev[IX_POS];
  assign n_fall      = ~cur[IX_NEG] & prev[IX_NEG];
  assign unused_prev = prev[IX_RTG];

  always_comb begin
    evt.fire   = (p_rise & ~cur[IX_NEG]) | (n_fall & cur[IX_POS]);
    evt.extend = p_rise & ~cur[IX_NEG] & cur[IX_RTG];
  end
endmodule

// File: rtl/oneshot_timebase.sv
module oneshot_timebase
  import oneshot_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic run,
  input  logic extend,
  output logic tap,
  output logic end_hit
);
  localparam int unsigned PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned RC_W = $clog2(END_RISES + 1);

  logic [PH_W-1:0] ph;
  logic [RC_W-1:0] rises;
  logic            wrap, rise;

  assign wrap    = (ph == PH_W'(HALF_CYC - 1));
  assign rise    = run & wrap & ~tap;
  assign end_hit = rise & ~extend & (rises == RC_W'(END_RISES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph    <= '0;
      tap   <= 1'b0;
      rises <= '0;
    end else if (start) begin
      ph    <= '0;
      tap   <= 1'b1;
      rises <= RC_W'(1);
    end else if (run) begin
      if (end_hit) begin
        ph    <= '0;
        tap   <= 1'b0;
        rises <= '0;
      end else begin
        ph <= wrap ? '0 : ph + 1'b1;
        if (wrap) tap <= ~tap;
        if (extend)    rises <= '0;
        else if (rise) rises <= rises + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig
  import oneshot_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mr,
  input  logic trig_pos,
  input  logic trig_neg,
  input  logic retrig_en,
  output logic pulse_o,
  output logic pulse_n,
  output logic osc_o
);
  logic [IN_BITS-1:0] raw, s_cur, s_prev;
  trig_evt_t          evt;
  logic               active, start, end_hit;

  always_comb begin
    raw         = '0;
    raw[IX_POS] = trig_pos;
    raw[IX_NEG] = trig_neg;
    raw[IX_RTG] = retrig_en;
  end

  oneshot_sync #(.N(IN_BITS)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .cur (s_cur),
    .prev(s_prev)
  );

  oneshot_edge_qual u_qual (
    .cur (s_cur),
    .prev(s_prev),
    .evt (evt)
  );

  assign start = ~active & evt.fire & ~mr;

  oneshot_timebase #(.HALF_CYC(HALF_CYC)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .clr    (mr),
    .start  (start),
    .run    (active),
    .extend (active & evt.extend),
    .tap    (osc_o),
    .end_hit(end_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || mr) begin
      active  <= 1'b0;
      pulse_n <= 1'b1;
    end else if (start) begin
      active  <= 1'b1;
      pulse_n <= 1'b0;
    end else if (end_hit) begin
      active  <= 1'b0;
      pulse_n <= 1'b1;
    end
  end

  assign pulse_o = active;
endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk #(
  parameter int unsigned HALF_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic mr,
  input logic pulse_o,
  input logic pulse_n,
  input logic osc_o
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)               hi_cnt <= '0;
    else if (!pulse_o)     hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r10_complement: assert property (@(posedge clk) disable iff (rst)
    pulse_o != pulse_n);

  a_r9_mr_clears: assert property (@(posedge clk) disable iff (rst)
    mr |=> (!pulse_o && !osc_o));

  a_r9_no_start_in_mr: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> !$past(mr));

  a_r8_idle_tap_low: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |-> !osc_o);

  a_r8_start_tap_high: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> osc_o);

  a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_o) && !$past(mr) && !$past(rst)) |-> (hi_cnt >= 16'(2 * HALF_CYC)));
endmodule

bind oneshot_retrig oneshot_retrig_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mr     (mr),
  .pulse_o(pulse_o),
  .pulse_n(pulse_n),
  .osc_o  (osc_o)
);

// File: tb/tb_oneshot_retrig.sv
`timescale 1ns/1ps
module tb_oneshot_retrig;
  localparam int H  = 4;
  localparam int P2 = 2 * H;

  logic clk = 1'b0, rst = 1'b1, mr = 1'b0;
  logic tp = 1'b0, tn = 1'b0, tr = 1'b0;
  logic pulse_o, pulse_n, osc_o;
  int   total = 0, bad = 0;

  always #2.5 clk = ~clk;

  oneshot_retrig #(.HALF_CYC(H)) dut (
    .clk(clk), .rst(rst), .mr(mr), .trig_pos(tp), .trig_neg(tn),
    .retrig_en(tr), .pulse_o(pulse_o), .pulse_n(pulse_n), .osc_o(osc_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: inputs take effect on the third edge after they change.
  logic [2:0] h1 = '0, h2 = '0, h3 = '0;  // {retrig, neg, pos}
  logic m_act = 1'b0;
  int   m_age = 0, m_rc = 0;

  always @(posedge clk) begin
    logic pr, nf, fire, ext;
    pr   = h2[0] & ~h3[0];
    nf   = ~h2[1] & h3[1];
    fire = (pr & ~h2[1]) | (nf & h2[0]);
    ext  = pr & ~h2[1] & h2[2];
    if (rst || mr) begin
      m_act = 1'b0; m_age = 0; m_rc = 0;
    end else if (!m_act) begin
      if (fire) begin m_act = 1'b1; m_age = 0; m_rc = 1; end
    end else begin
      m_age++;
      if (ext) m_rc = 0;
      else if (m_age % P2 == 0) begin
        if (m_rc == 1) m_act = 1'b0;
        else           m_rc++;
      end
    end
    if (rst) begin h1 = '0; h2 = '0; h3 = '0; end
    else begin h3 = h2; h2 = h1; h1 = {tr, tn, tp}; end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5", int'(pulse_o), int'(m_act));
      chk("R10", int'(pulse_n), int'(!m_act));
      chk("R8", int'(osc_o), int'(m_act && ((m_age % P2) < H)));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(string req, int exp_delay, int exp_width, int win);
    int first = -1, cnt = 0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (pulse_o) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
    if (exp_delay >= 0) chk(req, first, exp_delay);
    chk(req, cnt, exp_width);
  endtask

  function automatic int exp_retrig(int p, int n);
    int d = p * (n - 1);
    int r1 = (d / P2 + 1) * P2;
    return r1 + P2;
  endfunction

  task automatic retrig_train(int p, int n);
    fork
      begin
        for (int k = 0; k < n; k++) begin
          tp = 1'b1; tick(1); tp = 1'b0; tick(p - 1);
        end
      end
      measure("R7", 3, exp_retrig(p, n), 60);
    join
    tick(4);
  endtask

  task automatic main_seq();
    void'($urandom(32'd20240611));
    tick(3);
    chk("R1", int'(pulse_o), 0); chk("R1", int'(pulse_n), 1); chk("R1", int'(osc_o), 0);
    rst = 1'b0;
    tick(3);
    chk("R1", int'(pulse_o), 0); chk("R1", int'(osc_o), 0);
    // R2 + R5 long trigger held through whole window
    tp = 1'b1; measure("R2", 3, P2, 30); tp = 1'b0; tick(4);
    // R5 one-cycle trigger
    tp = 1'b1;
    fork begin tick(1); tp = 1'b0; end measure("R5", 3, P2, 30); join
    // R4: pos rise while neg high
    tn = 1'b1; tick(4); tp = 1'b1; measure("R4", -1, 0, 20);
    // R3: neg fall while pos high
    tn = 1'b0; measure("R3", 3, P2, 30);
    tp = 1'b0; measure("R4", -1, 0, 12);
    // R4: neg fall while pos low
    tn = 1'b1; tick(4); tn = 1'b0; measure("R4", -1, 0, 20);
    // R6: second edge during pulse without retrigger enable
    tp = 1'b1;
    fork
      begin tick(1); tp = 1'b0; tick(3); tp = 1'b1; tick(1); tp = 1'b0; end
      measure("R6", 3, P2, 30);
    join
    tick(4);
    // R7 retrigger trains, including spacing equal to 2*H
    tr = 1'b1;
    retrig_train(5, 4);
    retrig_train(3, 3);
    retrig_train(P2, 3);
    tr = 1'b0; tick(4);
    // R9: master reset cuts the pulse
    tp = 1'b1;
    fork
      begin tick(1); tp = 1'b0; tick(4); mr = 1'b1; tick(1); mr = 1'b0; end
      measure("R9", 3, 3, 30);
    join
    // R9: trigger decided while master reset high
    mr = 1'b1; tp = 1'b1;
    fork begin tick(1); tp = 1'b0; tick(6); mr = 1'b0; end measure("R9", -1, 0, 20); join
    // Random phase checked against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      @(negedge clk);
      r = int'($urandom % 100);
      if (r < 6)       tp = ~tp;
      else if (r < 10) tn = ~tn;
      else if (r < 13) tr = ~tr;
      mr = (($urandom % 250) == 0);
    end
    mr = 1'b0; tp = 1'b0; tn = 1'b0; tr = 1'b0;
    tick(40);
    // R1 again after a mid-run reset
    tp = 1'b1; tick(4); rst = 1'b1; tp = 1'b0; tick(2);
    chk("R1", int'(pulse_o), 0); chk("R1", int'(pulse_n), 1); chk("R1", int'(osc_o), 0);
    rst = 1'b0; tick(10);
    chk("R1", int'(pulse_o), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R5 watchdog actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule